// File: doc/BRIEF.md
# SECDED Codec for a 72-bit Memory Word

This block protects a 64-bit memory word with 8 check bits. The code corrects any single flipped bit and detects double errors. On the write side, combinational logic derives the check byte from the data. It also raises a write enable for the check lane, which tells the memory whether the stored check byte is to be replaced. On the read side, the block takes the stored data and check byte and forms the syndrome, the XOR of the regenerated check byte and the stored one. It looks the syndrome up among the 72 columns of a fixed parity-check matrix. If the syndrome matches a column, the block flips the bit at that column's index. If it does not match, the block reports the word as uncorrectable and passes the stored data through unchanged.

A two-bit mode input selects how the block behaves. Only the value 3 gives full protection: check bits are generated on write and checked and corrected on read. Every other value turns protection off. In that state the check lane write enable stays low, so a write changes only the data bits and the old check byte stays in memory. Reads then return the raw data with no error report. This is how single and double errors are planted for self-test.

The read results pass through one optional register stage, selected by a parameter. The stage is on by default, which gives a read latency of one clock.

Top module: `ecc_codec`

## Requirements
- R1: With mode 3, `wr_chk` bit b is the XOR of every `wr_data` bit i whose column has bit b set. `wr_chk_we` is 1. Data columns 0 to 63, in hex: F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B.
- R2: For mode values 0, 1 and 2, `wr_chk_we` is 0, so a write leaves the stored check byte unchanged.
- R3: With mode 3, a read whose syndrome is zero returns the stored data unchanged. It reports no error, a zero syndrome and a bit index of 0.
- R4: With mode 3, a single flipped data bit i is corrected in `q_data`. `q_corr` is set, `q_err` is set and `q_idx` equals i.
- R5: With mode 3, a single flipped stored check bit j gives syndrome 1<<j. The data is returned unchanged, `q_corr` is set and `q_idx` equals 71-j. Word indices 64 to 71 have the one-hot columns 80, 40, 20, 10, 08, 04, 02, 01.
- R6: With mode 3, a double error (data bits 29 and 30 flipped, for example) sets `q_uncorr` and `q_err` and clears `q_corr`. The stored data is returned unmodified and `q_idx` is 0.
- R7: With mode 3, a nonzero syndrome that matches no column is reported as uncorrectable. Stored check bits 0, 1 and 2 all flipped, giving syndrome 07, is one such case.
- R8: With mode other than 3, a read returns the raw stored data. `q_err`, `q_corr` and `q_uncorr` are 0, and `q_syn` and `q_idx` are 0.
- R9: With the output register enabled, `q_valid` is high exactly one cycle after each cycle in which `rd_valid` is high. The error flags are set only while `q_valid` is high. Reads may arrive back to back.
- R10: While `rst_n` is low, `q_valid`, the flags, `q_data`, `q_syn` and `q_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Protection mode; 3 = generate and check, other values = off |
| wr_data | input | 64 | Data being written |
| wr_chk | output | 8 | Check byte for wr_data |
| wr_chk_we | output | 1 | Write enable for the check lane |
| rd_valid | input | 1 | A stored word is presented on rd_data/rd_chk |
| rd_data | input | 64 | Stored data bits |
| rd_chk | input | 8 | Stored check bits |
| q_valid | output | 1 | Read result valid |
| q_data | output | 64 | Corrected (or raw) read data |
| q_err | output | 1 | Error strobe: correctable or uncorrectable |
| q_corr | output | 1 | Single error corrected |
| q_uncorr | output | 1 | Uncorrectable error detected |
| q_syn | output | 8 | Syndrome of the read |
| q_idx | output | 7 | Index of the corrected bit, valid with q_corr |

## Verification
The difficult condition to reach is a stored word whose data and check byte disagree. In normal use every write carries matching check bits, so a read never sees a mismatch. The bench models the memory by honouring `wr_chk_we`. It writes a pattern with protection on, then switches the mode off and writes a copy with one or two bits flipped. The old check byte stays in memory, and reading with protection back on exposes the planted error. Check-bit faults and the unmatched 07 syndrome cannot be made by writes, so the bench corrupts the modelled check byte directly. It also walks a flipped bit across all 64 data positions with reads issued back to back.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    PROT_OFF   = 2'b00,
    PROT_RSV_A = 2'b01,
    PROT_RSV_B = 2'b10,
    PROT_ON    = 2'b11
  } prot_mode_e;

  // Parity-check column for word bit idx (data 0..63, check 64..71).
  function automatic logic [CHK_W-1:0] column(input int unsigned idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0:  c = 8'hF4; 1:  c = 8'hF1; 2:  c = 8'hEC; 3:  c = 8'hEA;
      4:  c = 8'hE9; 5:  c = 8'hE6; 6:  c = 8'hE5; 7:  c = 8'hE3;
      8:  c = 8'hDC; 9:  c = 8'hDA; 10: c = 8'hD9; 11: c = 8'hD6;
      12: c = 8'hD5; 13: c = 8'hD3; 14: c = 8'hCE; 15: c = 8'hCB;
      16: c = 8'hB5; 17: c = 8'hB0; 18: c = 8'hAD; 19: c = 8'hAB;
      20: c = 8'hA8; 21: c = 8'hA7; 22: c = 8'hA4; 23: c = 8'hA2;
      24: c = 8'h9D; 25: c = 8'h9B; 26: c = 8'h98; 27: c = 8'h97;
      28: c = 8'h94; 29: c = 8'h92; 30: c = 8'h8F; 31: c = 8'h8A;
      32: c = 8'h75; 33: c = 8'h70; 34: c = 8'h6D; 35: c = 8'h6B;
      36: c = 8'h68; 37: c = 8'h67; 38: c = 8'h64; 39: c = 8'h62;
      40: c = 8'h5E; 41: c = 8'h5B; 42: c = 8'h58; 43: c = 8'h57;
      44: c = 8'h54; 45: c = 8'h52; 46: c = 8'h4F; 47: c = 8'h4A;
      48: c = 8'h34; 49: c = 8'h31; 50: c = 8'h2C; 51: c = 8'h2A;
      52: c = 8'h29; 53: c = 8'h26; 54: c = 8'h25; 55: c = 8'h23;
      56: c = 8'h1C; 57: c = 8'h1A; 58: c = 8'h19; 59: c = 8'h16;
      60: c = 8'h15; 61: c = 8'h13; 62: c = 8'h0E; 63: c = 8'h0B;
      default: c = (idx < WORD_W) ? (8'h80 >> (idx - DATA_W)) : '0;
    endcase
    return c;
  endfunction

  // Data bits that feed check bit b.
  function automatic logic [DATA_W-1:0] row_mask(input int unsigned b);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      logic [CHK_W-1:0] c;
      c = column(i);
      m[i] = c[b];
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_parity_gen.sv
module ecc_parity_gen
  import ecc_codec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  par
);

  for (genvar b = 0; b < CHK_W; b++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(b);
    assign par[b] = ^(data & MASK);
  end

endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
  import ecc_codec_pkg::*;
(
  input  logic [CHK_W-1:0]  syn,
  output logic [WORD_W-1:0] match,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  for (genvar i = 0; i < WORD_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = column(i);
    assign match[i] = (syn == COL);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |match;

  // R4: columns are distinct, so at most one comparator fires.
  always_comb begin
    if (!$isunknown(syn)) begin
      p_one_column_r4: assert ($onehot0(match))
        else $error("several columns match one syndrome");
    end
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_codec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [CHK_W-1:0]  syn,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] fixed
);

  logic [CHK_W-1:0]  regen;
  logic [WORD_W-1:0] match;

  ecc_parity_gen u_regen (
    .data (data),
    .par  (regen)
  );

  assign syn = regen ^ chk;

  ecc_locator u_loc (
    .syn   (syn),
    .match (match),
    .hit   (hit),
    .idx   (idx)
  );

  // Only data positions change the data; check positions flip nothing here.
  assign fixed = data ^ match[DATA_W-1:0];

endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_codec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [63:0]       wr_data,
  output logic [7:0]        wr_chk,
  output logic              wr_chk_we,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  input  logic [7:0]        rd_chk,
  output logic              q_valid,
  output logic [63:0]       q_data,
  output logic              q_err,
  output logic              q_corr,
  output logic              q_uncorr,
  output logic [7:0]        q_syn,
  output logic [6:0]        q_idx
);

  logic prot_on;
  assign prot_on = (prot_mode_e'(mode) == PROT_ON);

  // Write path.
  ecc_parity_gen u_enc (
    .data (wr_data),
    .par  (wr_chk)
  );
  assign wr_chk_we = prot_on;

  // Read path.
  logic [CHK_W-1:0]  d_syn;
  logic              d_hit;
  logic [IDX_W-1:0]  d_idx;
  logic [DATA_W-1:0] d_fixed;

  ecc_decoder u_dec (
    .data  (rd_data),
    .chk   (rd_chk),
    .syn   (d_syn),
    .hit   (d_hit),
    .idx   (d_idx),
    .fixed (d_fixed)
  );

  logic              c_nonzero, c_corr, c_uncorr;
  logic [DATA_W-1:0] c_data;
  logic [CHK_W-1:0]  c_syn;
  logic [IDX_W-1:0]  c_idx;

  always_comb begin
    c_nonzero = prot_on && (d_syn != '0);
    c_corr    = rd_valid && c_nonzero && d_hit;
    c_uncorr  = rd_valid && c_nonzero && !d_hit;
    c_data    = (c_nonzero && d_hit) ? d_fixed : rd_data;
    c_syn     = prot_on ? d_syn : '0;
    c_idx     = (c_nonzero && d_hit) ? d_idx : '0;
  end

  if (OUT_REG) begin : g_reg
    logic              r_valid, r_corr, r_uncorr;
    logic [DATA_W-1:0] r_data;
    logic [CHK_W-1:0]  r_syn;
    logic [IDX_W-1:0]  r_idx;
    logic              n_valid, n_corr, n_uncorr;
    logic [DATA_W-1:0] n_data;
    logic [CHK_W-1:0]  n_syn;
    logic [IDX_W-1:0]  n_idx;

    always_comb begin
      n_valid  = rd_valid;
      n_corr   = c_corr;
      n_uncorr = c_uncorr;
      n_data   = rd_valid ? c_data : r_data;
      n_syn    = rd_valid ? c_syn  : r_syn;
      n_idx    = rd_valid ? c_idx  : r_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_valid  <= 1'b0;
        r_corr   <= 1'b0;
        r_uncorr <= 1'b0;
        r_data   <= '0;
        r_syn    <= '0;
        r_idx    <= '0;
      end else begin
        r_valid  <= n_valid;
        r_corr   <= n_corr;
        r_uncorr <= n_uncorr;
        r_data   <= n_data;
        r_syn    <= n_syn;
        r_idx    <= n_idx;
      end
    end

    assign q_valid  = r_valid;
    assign q_corr   = r_corr;
    assign q_uncorr = r_uncorr;
    assign q_data   = r_data;
    assign q_syn    = r_syn;
    assign q_idx    = r_idx;

    // R4/R5: a corrected index names the column equal to the reported syndrome.
    p_idx_matches_syn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_corr |-> (column(int'(q_idx)) == q_syn))
      else $error("corrected index does not match syndrome");

    // R3: zero syndrome on a protected read returns the stored data untouched.
    p_clean_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && prot_on && (rd_chk == wr_chk) && (rd_data == wr_data))
        |=> (q_valid && !q_err && (q_syn == '0) && (q_data == $past(rd_data))))
      else $error("clean word altered or flagged");

    // R4: a corrected data bit differs from the stored word in exactly one place.
    p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_corr && (q_idx < IDX_W'(DATA_W)))
        |-> ($countones(q_data ^ $past(rd_data)) == 1))
      else $error("correction changed other than one bit");

    // R8: with protection off the read is raw and silent.
    p_off_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !prot_on) |=> (!q_err && (q_data == $past(rd_data))))
      else $error("unprotected read modified or flagged");

    // R9: flags only accompany a valid result; result follows a read by one cycle.
    p_flag_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_corr || q_uncorr) |-> q_valid)
      else $error("error flag without valid");
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> q_valid)
      else $error("read result missing");
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_corr && q_uncorr))
      else $error("corrected and uncorrectable together");
  end else begin : g_comb
    assign q_valid  = rd_valid;
    assign q_corr   = c_corr;
    assign q_uncorr = c_uncorr;
    assign q_data   = c_data;
    assign q_syn    = c_syn;
    assign q_idx    = c_idx;
  end

  assign q_err = q_corr | q_uncorr;

endmodule

// File: tb/sim_ecc_codec.sv
module sim_ecc_codec;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [63:0] wr_data;
  logic [7:0]  wr_chk;
  logic        wr_chk_we;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [7:0]  rd_chk;
  logic        q_valid;
  logic [63:0] q_data;
  logic        q_err, q_corr, q_uncorr;
  logic [7:0]  q_syn;
  logic [6:0]  q_idx;

  ecc_codec u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_data(wr_data), .wr_chk(wr_chk), .wr_chk_we(wr_chk_we),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
    .q_valid(q_valid), .q_data(q_data), .q_err(q_err), .q_corr(q_corr),
    .q_uncorr(q_uncorr), .q_syn(q_syn), .q_idx(q_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  int cycle   = 0;
  bit done    = 0;
  bit armed   = 0;

  always @(posedge clk) cycle <= cycle + 1;

  logic [7:0] tbl [64];
  initial begin
    tbl = '{8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
            8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
            8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
            8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
            8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
            8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
            8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
            8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};
  end

  function automatic logic [7:0] ref_col(int i);
    return (i < 64) ? tbl[i] : (8'h80 >> (i - 64));
  endfunction

  function automatic logic [7:0] ref_chk(logic [63:0] d);
    logic [7:0] p = '0;
    for (int i = 0; i < 64; i++) if (d[i]) p = p ^ tbl[i];
    return p;
  endfunction

  typedef struct {
    logic [63:0] d;
    logic        e, c, u;
    logic [7:0]  s;
    logic [6:0]  x;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // Modelled memory word.
  logic [63:0] mem_d;
  logic [7:0]  mem_c;

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // Driver: write a word through the codec into the modelled memory.
  task automatic do_write(logic [1:0] m, logic [63:0] d, string tag);
    @(negedge clk);
    rd_valid = 1'b0;
    mode     = m;
    wr_data  = d;
    #1;
    if (m == 2'b11) begin
      check(tag, 128'(wr_chk), 128'(ref_chk(d)), "wr_chk");
      check(tag, 128'(wr_chk_we), 128'(1), "wr_chk_we");
    end else begin
      check(tag, 128'(wr_chk_we), 128'(0), "wr_chk_we");
    end
    mem_d = d;
    if (wr_chk_we) mem_c = wr_chk;
  endtask

  // Driver: present the memory word and push the predicted result.
  task automatic do_read(logic [1:0] m, string tag);
    exp_t e;
    logic [7:0] s;
    @(negedge clk);
    mode     = m;
    rd_valid = 1'b1;
    rd_data  = mem_d;
    rd_chk   = mem_c;
    e.d = mem_d; e.e = 0; e.c = 0; e.u = 0; e.s = '0; e.x = '0;
    e.cyc = cycle; e.tag = tag;
    if (m == 2'b11) begin
      s = ref_chk(mem_d) ^ mem_c;
      e.s = s;
      if (s != 0) begin
        e.e = 1; e.u = 1;
        for (int i = 0; i < 72; i++) begin
          if (ref_col(i) == s) begin
            e.u = 0; e.c = 1; e.x = 7'(i);
            if (i < 64) e.d = mem_d ^ (64'd1 << i);
          end
        end
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rd_valid = 1'b0;
    end
  endtask

  // Monitor: compare each result in the cycle it is due (R9).
  always @(negedge clk) begin
    if (armed) begin
      bit due;
      due = (sb.size() > 0) && (sb[0].cyc + 1 == cycle);
      if (q_valid !== due) begin
        vectors++; misses++;
        $display("FAIL R9 q_valid: got %0b expected %0b", q_valid, due);
      end
      if (due) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, 128'(q_data), 128'(e.d), "q_data");
        check(e.tag, 128'({q_err, q_corr, q_uncorr}), 128'({e.e, e.c, e.u}), "err/corr/uncorr");
        check(e.tag, 128'(q_syn), 128'(e.s), "q_syn");
        check(e.tag, 128'(q_idx), 128'(e.x), "q_idx");
      end else if (!q_valid) begin
        check("R9", 128'({q_corr, q_uncorr}), 128'(0), "flags while idle");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [63:0] PAT = 64'h0123_4567_0101_0101;

  initial begin
    logic [63:0] lfsr;
    rst_n = 1'b0; mode = 2'b11; wr_data = '0;
    rd_valid = 1'b0; rd_data = '0; rd_chk = '0;
    mem_d = '0; mem_c = '0;
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10", 128'({q_valid, q_err, q_corr, q_uncorr}), 128'(0), "flags in reset");
    check("R10", 128'(q_data), 128'(0), "q_data in reset");
    check("R10", 128'({q_syn, q_idx}), 128'(0), "syn/idx in reset");
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1;

    // R1 then R3: protected write and clean read
    do_write(2'b11, PAT, "R1");
    do_read(2'b11, "R3");
    idle(1);

    // R2 + R8: unprotected write keeps the old check byte, read is raw
    for (int m = 0; m < 3; m++) begin
      do_write(2'(m), PAT ^ (64'd1 << 28), "R2");
      do_read(2'(m), "R8");
    end
    // R4: planted single data error now corrected (bit 28)
    do_read(2'b11, "R4");
    idle(1);

    // R6: double error in bits 29 and 30
    do_write(2'b00, PAT ^ (64'd3 << 29), "R2");
    do_read(2'b11, "R6");
    idle(1);

    // R5: each stored check bit flipped
    do_write(2'b11, PAT, "R1");
    for (int j = 0; j < 8; j++) begin
      mem_c = ref_chk(PAT) ^ (8'd1 << j);
      do_read(2'b11, "R5");
    end
    // R7: syndrome 07 matches no column
    mem_c = ref_chk(PAT) ^ 8'h07;
    do_read(2'b11, "R7");
    idle(1);

    // R4 + R9: walk a flipped data bit across all positions, back to back
    do_write(2'b11, ~PAT, "R1");
    for (int i = 0; i < 64; i++) begin
      mem_d = ~PAT ^ (64'd1 << i);
      do_read(2'b11, "R4");
    end
    idle(2);

    // R1: varied data patterns
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 12; k++) begin
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      do_write(2'b11, lfsr, "R1");
      do_read(2'b11, "R3");
    end
    do_write(2'b11, 64'h0, "R1");
    do_write(2'b11, '1, "R1");
    idle(3);

    if (sb.size() != 0) begin
      vectors++; misses++;
      $display("FAIL R9 pending results: got %0d expected 0", sb.size());
    end
    finish_run();
  end

endmodule